// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Address-Space Tagging

This block caches virtual-to-physical page translations in a small, fully associative array. Every slot holds a virtual page tag, a physical page number, an address-space identifier, a global flag, per-privilege read and write enable masks, two fault-on-access flags and a valid flag. A combinational lookup port takes a virtual page number and the current address-space identifier. In the same cycle it reports whether a translation exists and, if so, returns the stored fields of that slot.

Slots are filled in round-robin order. A replacement pointer names the next slot to overwrite, and each insert advances it. The same pointer drives a read-back port that shows the slot it names. A read command can step the pointer without writing anything. Three invalidation commands are provided: one clears the whole array, one drops only the entries that are not global, and one drops the entries that match a given page within a given address space. Pages are 8 KB. The page number is bits 42:13 of the 43-bit virtual address, and bits 12:0 are the page offset, which the block ignores.

The command port has no internal states. The decoder is a one-cycle dispatch on the command code. Each legal code performs one named transition of the array and pointer at the next clock edge, and the idle code and the undefined codes leave both untouched.

Top module: `asn_tlb`

## Requirements
- R1: After reset, every slot is invalid, the replacement pointer is 0, and a lookup of any page misses.
- R2: A lookup hits only on a valid slot whose tag equals the requested page number and which is either global or stores the requested address-space identifier. The result appears in the same cycle as the request.
- R3: On a hit, the port returns the hitting slot's index, physical page number, read and write enable masks, fault-on-read and fault-on-write flags, and global flag.
- R4: When several slots match, the lowest-numbered slot is reported. The exposed match vector has exactly that one bit set, or no bits set on a miss.
- R5: Code 1 (insert) writes the slot named by the pointer, overwriting it even if it is valid. It stores the tag from address bits 42:13, sets the valid flag, and advances the pointer by one.
- R6: The pointer wraps from ENTRIES-1 back to 0.
- R7: Code 2 (clear all) zeroes every slot, including its valid flag, and returns the pointer to 0.
- R8: Code 3 (drop private) invalidates every slot whose global flag is clear and leaves global slots usable.
- R9: Code 4 (drop page) invalidates every slot that matches the page and address-space identifier of the command under the lookup rule of R2. Slots that do not match stay usable.
- R10: The read-back port always shows the valid flag, tag, identifier, physical page and global flag of the slot under the pointer. Code 5 (read) advances the pointer only when the advance input is 1.
- R11: Code 0 and codes 6 and 7 change neither the array nor the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | 30 | Page number to look up |
| lk_asn | input | 8 | Current address-space identifier |
| lk_hit | output | 1 | Lookup found a translation |
| lk_idx | output | 6 | Index of the hitting slot |
| lk_onehot | output | ENTRIES | One-hot vector of the selected slot |
| lk_ppn | output | 28 | Physical page number of the hit |
| lk_rd_en | output | 4 | Per-mode read enables of the hit |
| lk_wr_en | output | 4 | Per-mode write enables of the hit |
| lk_fault_rd | output | 1 | Fault-on-read flag of the hit |
| lk_fault_wr | output | 1 | Fault-on-write flag of the hit |
| lk_global | output | 1 | Global flag of the hit |
| cmd_op | input | 3 | Command code (0 idle, 1 insert, 2 clear all, 3 drop private, 4 drop page, 5 read) |
| cmd_va | input | 43 | Virtual address for insert and drop page |
| cmd_asn | input | 8 | Address-space identifier for insert and drop page |
| cmd_ppn | input | 28 | Physical page for insert |
| cmd_global | input | 1 | Global flag for insert |
| cmd_rd_en | input | 4 | Read enables for insert |
| cmd_wr_en | input | 4 | Write enables for insert |
| cmd_fault_rd | input | 1 | Fault-on-read flag for insert |
| cmd_fault_wr | input | 1 | Fault-on-write flag for insert |
| cmd_advance | input | 1 | Step the pointer on a read command |
| victim_ptr | output | 6 | Current replacement pointer |
| rd_valid | output | 1 | Valid flag of the slot under the pointer |
| rd_vpn | output | 30 | Tag of the slot under the pointer |
| rd_asn | output | 8 | Identifier of the slot under the pointer |
| rd_ppn | output | 28 | Physical page of the slot under the pointer |
| rd_global | output | 1 | Global flag of the slot under the pointer |

## Verification
Lookups are tried with the correct identifier, with a wrong identifier against a private entry, and with a wrong identifier against a global entry. These cases separate the tag test from the identifier-or-global test. Two slots that share a page, one private and one global, show whether the lowest-index priority holds and whether the identifier picks which slot answers. The invalidation commands run on a mix of global and private slots. These runs show whether drop private spares global slots, and whether drop page removes a global alias but spares a private slot of another identifier. A full ring of inserts followed by one more insert shows the pointer wrapping and the oldest slot being overwritten.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
    parameter int VA_W       = 43;
    parameter int PAGE_SHIFT = 13;
    parameter int PPN_W      = 28;
    parameter int ASN_W      = 8;
    parameter int MODE_W     = 4;
    localparam int VPN_W     = VA_W - PAGE_SHIFT;

    // Command codes on cmd_op
    typedef enum logic [2:0] {
        OP_IDLE       = 3'd0,
        OP_INSERT     = 3'd1,
        OP_CLEAR_ALL  = 3'd2,
        OP_DROP_PRIV  = 3'd3,
        OP_DROP_PAGE  = 3'd4,
        OP_READ       = 3'd5
    } tlb_op_e;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  tag;
        logic [ASN_W-1:0]  asn;
        logic              glob;
        logic [PPN_W-1:0]  ppn;
        logic [MODE_W-1:0] rd_en;
        logic [MODE_W-1:0] wr_en;
        logic              fault_rd;
        logic              fault_wr;
    } tlb_entry_t;
endpackage

// File: rtl/tlbx_match.sv
module tlbx_match
    import tlbx_pkg::*;
#(
    parameter int ENTRIES = 48
) (
    input  tlb_entry_t         ents [ENTRIES],
    input  logic [VPN_W-1:0]   vpn,
    input  logic [ASN_W-1:0]   asn,
    output logic [ENTRIES-1:0] hits
);
    // One comparator per slot: tag equal and (global or same space)
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hits[i] = ents[i].valid && (ents[i].tag == vpn) &&
                         (ents[i].glob || (ents[i].asn == asn));
    end
endmodule

// File: rtl/tlbx_prio.sv
module tlbx_prio #(
    parameter int ENTRIES = 48,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] req,
    output logic [ENTRIES-1:0] gnt,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);
    // Lowest index wins: scan downward so the last write is the lowest set bit
    always_comb begin
        gnt = '0;
        idx = '0;
        any = |req;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlbx_victim.sv
module tlbx_victim #(
    parameter int ENTRIES = 48,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= '0;
        else if (clear)  ptr <= '0;
        else if (step)   ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && ptr == LAST) |=> (ptr == '0));

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
    import tlbx_pkg::*;
#(
    parameter int ENTRIES = 48,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [29:0]        lk_vpn,
    input  logic [7:0]         lk_asn,
    output logic               lk_hit,
    output logic [IDX_W-1:0]   lk_idx,
    output logic [ENTRIES-1:0] lk_onehot,
    output logic [27:0]        lk_ppn,
    output logic [3:0]         lk_rd_en,
    output logic [3:0]         lk_wr_en,
    output logic               lk_fault_rd,
    output logic               lk_fault_wr,
    output logic               lk_global,
    input  logic [2:0]         cmd_op,
    input  logic [42:0]        cmd_va,
    input  logic [7:0]         cmd_asn,
    input  logic [27:0]        cmd_ppn,
    input  logic               cmd_global,
    input  logic [3:0]         cmd_rd_en,
    input  logic [3:0]         cmd_wr_en,
    input  logic               cmd_fault_rd,
    input  logic               cmd_fault_wr,
    input  logic               cmd_advance,
    output logic [IDX_W-1:0]   victim_ptr,
    output logic               rd_valid,
    output logic [29:0]        rd_vpn,
    output logic [7:0]         rd_asn,
    output logic [27:0]        rd_ppn,
    output logic               rd_global
);
    tlb_entry_t           ents [ENTRIES];
    tlb_entry_t           new_ent;
    tlb_entry_t           hit_ent;
    tlb_entry_t           vic_ent;
    logic [VPN_W-1:0]     cmd_vpn;
    logic [ENTRIES-1:0]   lk_match;
    logic [ENTRIES-1:0]   page_match;
    logic [ENTRIES-1:0]   valid_vec;
    logic [ENTRIES-1:0]   glob_vec;
    logic [IDX_W-1:0]     vptr;
    logic                 ptr_step;
    logic                 ptr_clear;
    logic                 unused_offset;

    assign cmd_vpn       = cmd_va[VA_W-1:PAGE_SHIFT];
    assign unused_offset = ^cmd_va[PAGE_SHIFT-1:0];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_flags
        assign valid_vec[i] = ents[i].valid;
        assign glob_vec[i]  = ents[i].glob;
    end

    // Lookup path
    tlbx_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .ents(ents), .vpn(lk_vpn), .asn(lk_asn), .hits(lk_match)
    );

    tlbx_prio #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lk_prio (
        .req(lk_match), .gnt(lk_onehot), .idx(lk_idx), .any(lk_hit)
    );

    // Page-drop path uses the same match rule
    tlbx_match #(.ENTRIES(ENTRIES)) u_page_match (
        .ents(ents), .vpn(cmd_vpn), .asn(cmd_asn), .hits(page_match)
    );

    // Command decode: one-cycle dispatch, every code named
    always_comb begin
        ptr_step  = 1'b0;
        ptr_clear = 1'b0;
        unique case (cmd_op)
            OP_INSERT:    ptr_step  = 1'b1;
            OP_CLEAR_ALL: ptr_clear = 1'b1;
            OP_READ:      ptr_step  = cmd_advance;
            default:      ;
        endcase
    end

    tlbx_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk(clk), .rst_n(rst_n), .clear(ptr_clear), .step(ptr_step), .ptr(vptr)
    );

    always_comb begin
        new_ent          = '0;
        new_ent.valid    = 1'b1;
        new_ent.tag      = cmd_vpn;
        new_ent.asn      = cmd_asn;
        new_ent.glob     = cmd_global;
        new_ent.ppn      = cmd_ppn;
        new_ent.rd_en    = cmd_rd_en;
        new_ent.wr_en    = cmd_wr_en;
        new_ent.fault_rd = cmd_fault_rd;
        new_ent.fault_wr = cmd_fault_wr;
    end

    // Entry array state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ents[i] <= '0;
        end else begin
            unique case (cmd_op)
                OP_INSERT: ents[vptr] <= new_ent;
                OP_CLEAR_ALL: begin
                    for (int i = 0; i < ENTRIES; i++) ents[i] <= '0;
                end
                OP_DROP_PRIV: begin
                    for (int i = 0; i < ENTRIES; i++)
                        if (!ents[i].glob) ents[i].valid <= 1'b0;
                end
                OP_DROP_PAGE: begin
                    for (int i = 0; i < ENTRIES; i++)
                        if (page_match[i]) ents[i].valid <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Output views
    always_comb begin
        hit_ent     = ents[lk_idx];
        lk_ppn      = lk_hit ? hit_ent.ppn      : '0;
        lk_rd_en    = lk_hit ? hit_ent.rd_en    : '0;
        lk_wr_en    = lk_hit ? hit_ent.wr_en    : '0;
        lk_fault_rd = lk_hit && hit_ent.fault_rd;
        lk_fault_wr = lk_hit && hit_ent.fault_wr;
        lk_global   = lk_hit && hit_ent.glob;
        vic_ent     = ents[vptr];
        victim_ptr  = vptr;
        rd_valid    = vic_ent.valid;
        rd_vpn      = vic_ent.tag;
        rd_asn      = vic_ent.asn;
        rd_ppn      = vic_ent.ppn;
        rd_global   = vic_ent.glob;
    end

    // Assertions
    assert_lookup_rule_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (ents[lk_idx].valid && ents[lk_idx].tag == lk_vpn &&
                    (ents[lk_idx].glob || ents[lk_idx].asn == lk_asn)));

    assert_single_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_onehot) && (lk_hit == (lk_onehot != '0)));

    assert_insert_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_INSERT) |=>
            (ents[$past(vptr)].valid && ents[$past(vptr)].tag == $past(cmd_vpn)));

    assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_CLEAR_ALL) |=> (valid_vec == '0 && vptr == '0));

    assert_drop_priv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_DROP_PRIV) |=> ((valid_vec & ~glob_vec) == '0));

    assert_drop_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_DROP_PAGE) |=> ((valid_vec & $past(page_match)) == '0));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_IDLE || cmd_op > OP_READ) |=>
            (valid_vec == $past(valid_vec) && vptr == $past(vptr)));
endmodule

// File: tb/asn_tlb_bench.sv
module asn_tlb_bench;
    localparam int N = 48;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [29:0] lk_vpn;
    logic [7:0]  lk_asn;
    logic        lk_hit;
    logic [5:0]  lk_idx;
    logic [N-1:0] lk_onehot;
    logic [27:0] lk_ppn;
    logic [3:0]  lk_rd_en, lk_wr_en;
    logic        lk_fault_rd, lk_fault_wr, lk_global;
    logic [2:0]  cmd_op;
    logic [42:0] cmd_va;
    logic [7:0]  cmd_asn;
    logic [27:0] cmd_ppn;
    logic        cmd_global;
    logic [3:0]  cmd_rd_en, cmd_wr_en;
    logic        cmd_fault_rd, cmd_fault_wr, cmd_advance;
    logic [5:0]  victim_ptr;
    logic        rd_valid;
    logic [29:0] rd_vpn;
    logic [7:0]  rd_asn;
    logic [27:0] rd_ppn;
    logic        rd_global;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    asn_tlb #(.ENTRIES(N)) u_asn_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_idx(lk_idx),
        .lk_onehot(lk_onehot), .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en),
        .lk_wr_en(lk_wr_en), .lk_fault_rd(lk_fault_rd), .lk_fault_wr(lk_fault_wr),
        .lk_global(lk_global), .cmd_op(cmd_op), .cmd_va(cmd_va), .cmd_asn(cmd_asn),
        .cmd_ppn(cmd_ppn), .cmd_global(cmd_global), .cmd_rd_en(cmd_rd_en),
        .cmd_wr_en(cmd_wr_en), .cmd_fault_rd(cmd_fault_rd), .cmd_fault_wr(cmd_fault_wr),
        .cmd_advance(cmd_advance), .victim_ptr(victim_ptr), .rd_valid(rd_valid),
        .rd_vpn(rd_vpn), .rd_asn(rd_asn), .rd_ppn(rd_ppn), .rd_global(rd_global)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Issue one command for one clock, return at the following negedge
    task automatic cmd(input logic [2:0] op, input logic [29:0] vpn, input logic [7:0] asn,
                       input logic [27:0] ppn, input logic glob, input logic adv);
        @(negedge clk);
        cmd_op       = op;
        cmd_va       = {vpn, 13'h15a5};
        cmd_asn      = asn;
        cmd_ppn      = ppn;
        cmd_global   = glob;
        cmd_rd_en    = vpn[3:0];
        cmd_wr_en    = ~vpn[3:0];
        cmd_fault_rd = vpn[0];
        cmd_fault_wr = vpn[1];
        cmd_advance  = adv;
        @(negedge clk);
        cmd_op = 3'd0;
        #1;
    endtask

    task automatic ins(input logic [29:0] vpn, input logic [7:0] asn,
                       input logic [27:0] ppn, input logic glob);
        cmd(3'd1, vpn, asn, ppn, glob, 1'b0);
    endtask

    task automatic look(input logic [29:0] vpn, input logic [7:0] asn);
        lk_vpn = vpn;
        lk_asn = asn;
        #1;
    endtask

    task automatic t_reset;
        check(victim_ptr == 0, "R1", "pointer after reset", victim_ptr, 0);
        check(rd_valid == 0, "R1", "slot 0 valid after reset", rd_valid, 0);
        look(30'h0, 8'h0);
        check(lk_hit == 0, "R1", "hit on zero page after reset", lk_hit, 0);
        look(30'h1234, 8'h3);
        check(lk_hit == 0, "R1", "hit after reset", lk_hit, 0);
    endtask

    task automatic t_insert_lookup;
        ins(30'h1a2b3, 8'h03, 28'h0abcd, 1'b0);
        check(victim_ptr == 1, "R5", "pointer after insert", victim_ptr, 1);
        look(30'h1a2b3, 8'h03);
        check(lk_hit == 1, "R2", "hit with own asn", lk_hit, 1);
        check(lk_idx == 0, "R3", "hit index", lk_idx, 0);
        check(lk_ppn == 28'h0abcd, "R3", "ppn", lk_ppn, 28'h0abcd);
        check(lk_rd_en == 4'h3 && lk_wr_en == 4'hc, "R3", "mode masks",
              {lk_rd_en, lk_wr_en}, 8'h3c);
        check(lk_fault_rd == 1 && lk_fault_wr == 1 && lk_global == 0, "R3", "flags",
              {lk_fault_rd, lk_fault_wr, lk_global}, 3'b110);
        look(30'h1a2b3, 8'h04);
        check(lk_hit == 0, "R2", "private entry, other asn", lk_hit, 0);
        look(30'h1a2b2, 8'h03);
        check(lk_hit == 0, "R2", "neighbour page", lk_hit, 0);
        ins(30'h00777, 8'h05, 28'h00111, 1'b1);
        look(30'h00777, 8'h99);
        check(lk_hit == 1 && lk_idx == 1, "R2", "global entry, foreign asn",
              {lk_hit, lk_idx}, {1'b1, 6'd1});
        check(lk_global == 1, "R3", "global flag", lk_global, 1);
    endtask

    task automatic t_priority;
        ins(30'h0dddd, 8'h07, 28'h0aaaa, 1'b0);
        ins(30'h0dddd, 8'h01, 28'h0bbbb, 1'b1);
        look(30'h0dddd, 8'h07);
        check(lk_idx == 2 && lk_ppn == 28'h0aaaa, "R4", "lowest index wins",
              lk_idx, 2);
        check(lk_onehot == (48'd1 << 2), "R4", "one-hot vector", lk_onehot, 48'd1 << 2);
        look(30'h0dddd, 8'h01);
        check(lk_idx == 3 && lk_ppn == 28'h0bbbb, "R4", "only global matches",
              lk_idx, 3);
        look(30'h0eeee, 8'h01);
        check(lk_onehot == 0, "R4", "vector on miss", lk_onehot, 0);
    endtask

    task automatic t_read_port;
        check(victim_ptr == 4 && rd_valid == 0, "R10", "empty slot under pointer",
              {victim_ptr, rd_valid}, {6'd4, 1'b0});
        cmd(3'd5, 30'h0, 8'h0, 28'h0, 1'b0, 1'b0);
        check(victim_ptr == 4, "R10", "read without advance", victim_ptr, 4);
        cmd(3'd5, 30'h0, 8'h0, 28'h0, 1'b0, 1'b1);
        check(victim_ptr == 5, "R10", "read with advance", victim_ptr, 5);
        ins(30'h04444, 8'h22, 28'h04242, 1'b1);
        check(victim_ptr == 6, "R5", "insert after read step", victim_ptr, 6);
        cmd(3'd2, 30'h0, 8'h0, 28'h0, 1'b0, 1'b0);
        ins(30'h05555, 8'h33, 28'h05353, 1'b1);
        cmd(3'd5, 30'h0, 8'h0, 28'h0, 1'b0, 1'b0);
        cmd(3'd5, 30'h0, 8'h0, 28'h0, 1'b0, 1'b1);
        check(victim_ptr == 2, "R10", "pointer after second step", victim_ptr, 2);
    endtask

    task automatic t_ignored;
        logic [5:0] p0;
        p0 = victim_ptr;
        cmd(3'd7, 30'h0beef, 8'h02, 28'h0c0de, 1'b1, 1'b1);
        cmd(3'd6, 30'h0beef, 8'h02, 28'h0c0de, 1'b1, 1'b1);
        cmd(3'd0, 30'h0beef, 8'h02, 28'h0c0de, 1'b1, 1'b1);
        look(30'h0beef, 8'h02);
        check(lk_hit == 0, "R11", "undefined code inserted", lk_hit, 0);
        check(victim_ptr == p0, "R11", "undefined code moved pointer", victim_ptr, p0);
    endtask

    task automatic t_flush_rebuild;
        cmd(3'd2, 30'h0, 8'h0, 28'h0, 1'b0, 1'b0);
        check(victim_ptr == 0, "R7", "pointer after clear", victim_ptr, 0);
        look(30'h05555, 8'h33);
        check(lk_hit == 0, "R7", "hit after clear", lk_hit, 0);
        check(rd_valid == 0 && rd_vpn == 0 && rd_ppn == 0, "R7", "slot 0 contents",
              rd_ppn, 0);
        ins(30'h1a2b3, 8'h03, 28'h0abcd, 1'b0);
        ins(30'h00777, 8'h05, 28'h00111, 1'b1);
        ins(30'h0dddd, 8'h07, 28'h0aaaa, 1'b0);
        ins(30'h0dddd, 8'h01, 28'h0bbbb, 1'b1);
    endtask

    task automatic t_drop_page;
        cmd(3'd4, 30'h1a2b3, 8'h04, 28'h0, 1'b0, 1'b0);
        look(30'h1a2b3, 8'h03);
        check(lk_hit == 1, "R9", "private slot of other asn kept", lk_hit, 1);
        cmd(3'd4, 30'h0dddd, 8'h07, 28'h0, 1'b0, 1'b0);
        look(30'h0dddd, 8'h07);
        check(lk_hit == 0, "R9", "matching private slot dropped", lk_hit, 0);
        look(30'h0dddd, 8'h01);
        check(lk_hit == 0, "R9", "matching global alias dropped", lk_hit, 0);
        look(30'h00777, 8'h05);
        check(lk_hit == 1, "R9", "unrelated page kept", lk_hit, 1);
    endtask

    task automatic t_drop_priv;
        cmd(3'd3, 30'h0, 8'h0, 28'h0, 1'b0, 1'b0);
        look(30'h1a2b3, 8'h03);
        check(lk_hit == 0, "R8", "private entry dropped", lk_hit, 0);
        look(30'h00777, 8'h42);
        check(lk_hit == 1 && lk_ppn == 28'h00111, "R8", "global entry kept",
              lk_ppn, 28'h00111);
        check(victim_ptr == 4, "R8", "pointer untouched", victim_ptr, 4);
        cmd(3'd2, 30'h0, 8'h0, 28'h0, 1'b0, 1'b0);
        look(30'h00777, 8'h42);
        check(lk_hit == 0, "R7", "global dropped by clear all", lk_hit, 0);
    endtask

    task automatic t_wrap;
        for (int i = 0; i < N; i++) ins(30'(100 + i), 8'(i), 28'(1000 + i), 1'b0);
        check(victim_ptr == 0, "R6", "pointer wrapped", victim_ptr, 0);
        look(30'd147, 8'd47);
        check(lk_hit == 1 && lk_idx == 47, "R6", "last slot filled", lk_idx, 47);
        ins(30'd500, 8'd9, 28'd5000, 1'b0);
        look(30'd100, 8'd0);
        check(lk_hit == 0, "R5", "overwritten slot gone", lk_hit, 0);
        look(30'd500, 8'd9);
        check(lk_hit == 1 && lk_idx == 0 && lk_ppn == 28'd5000, "R5",
              "new entry in slot 0", lk_idx, 0);
        look(30'd101, 8'd1);
        check(lk_hit == 1 && lk_idx == 1, "R6", "slot 1 intact", lk_idx, 1);
        check(victim_ptr == 1 && rd_vpn == 30'd101 && rd_asn == 8'd1, "R10",
              "read port shows slot 1", rd_vpn, 101);
    endtask

    initial begin
        rst_n = 1'b0; cmd_op = 3'd0; cmd_va = '0; cmd_asn = '0; cmd_ppn = '0;
        cmd_global = 1'b0; cmd_rd_en = '0; cmd_wr_en = '0; cmd_fault_rd = 1'b0;
        cmd_fault_wr = 1'b0; cmd_advance = 1'b0; lk_vpn = '0; lk_asn = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset;
        t_insert_lookup;
        t_priority;
        t_read_port;
        t_ignored;
        t_flush_rebuild;
        t_drop_page;
        t_drop_priv;
        t_wrap;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule